// File: doc/BRIEF.md
# Symmetric bit-serial distributed-arithmetic FIR section

This block computes one fourth-order, linear-phase FIR section with five taps whose coefficients mirror about the centre (outer pair shares one weight, inner pair another). Samples are taken in parallel through a valid/ready handshake and kept in a five-deep history. Each frame then walks the samples bit by bit, LSB first. Two serial full adders form the outer-pair and inner-pair sums, with carry carried between cycles. The two sum bits and the centre-tap bit address an eight-entry table of coefficient sums.

A shift-accumulator weights each table word by its bit position and subtracts the word of the sign cycle. The product is rounded to the input width with saturation. It is presented on a parallel output with a one-cycle valid pulse. The output width equals the input width, so several sections can be chained, each section's output feeding the next one's input.

Each sample is sign-extended by one bit so that a pair sum cannot overflow, which gives N+1 bit cycles. Two alignment stages (pre-adder register, table register) add to this. A frame is therefore N+3 cycles long, and that is also the minimum sample interval.

Top module: `da_sym_section`

## Requirements
- R1: During and right after reset, in_ready_o is 1, out_valid_o is 0 and out_sample_o is 0. The sample history is all zero.
- R2: Samples and results are N-bit two's complement. With x0 the newest accepted sample and x4 the oldest, the result is round(H0*(x0+x4) + H1*(x1+x3) + H2*x2, FRAC).
- R3: out_valid_o is high for exactly one cycle, beginning on the (N+3)th rising edge after the edge that accepted the sample.
- R4: A sample is accepted on an edge where in_valid_i and in_ready_o are both 1. After that, in_ready_o is 0 for N+2 cycles and returns to 1 in the last cycle of the frame. A new sample can therefore be accepted every N+3 cycles.
- R5: in_valid_i asserted while in_ready_o is 0 has no effect on the history or on any later result.
- R6: Pair sums are exact for every input, including when both taps of a pair hold -2^(N-1) or 2^(N-1)-1.
- R7: Rounding adds 2^(FRAC-1) and then shifts right arithmetically by FRAC bits, so exact halves go toward positive infinity.
- R8: A rounded value above 2^(N-1)-1 or below -2^(N-1) is clamped to that limit.
- R9: A sample accepted on the same edge that emits the previous result leaves both results correct.
- R10: out_sample_o holds its value in every cycle in which out_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample offered |
| in_sample_i | input | N | Signed input sample |
| in_ready_o | output | 1 | Section can accept a sample on this edge |
| out_valid_o | output | 1 | One-cycle pulse, result present |
| out_sample_o | output | N | Rounded, saturated signed result |

## Verification
When in_valid_i is held high continuously, a new sample is accepted on the same edge on which the final sign-cycle subtraction of the previous frame completes and its result is emitted. In that cycle, the history shift and pre-adder carry clear for the new frame coincide with the accumulator finishing the old frame. The bench streams samples this way and, on every falling edge, compares in_ready_o, out_valid_o and out_sample_o with a behavioural model. That model shifts a queue and evaluates the rounded formula, so a frame that bleeds into its neighbour shows up as a wrong value or a misplaced pulse.

// File: rtl/da_sym_pkg.sv
package da_sym_pkg;
  localparam int unsigned TAB_ADDR_W = 3;
  localparam int unsigned TAPS       = 5;
  localparam int unsigned PIPE_LAT   = 2;

  // table word: bit0 selects outer-pair weight, bit1 inner-pair, bit2 centre
  function automatic int da_entry(int h0, int h1, int h2, logic [TAB_ADDR_W-1:0] sel);
    int s;
    s = 0;
    if (sel[0]) s = s + h0;
    if (sel[1]) s = s + h1;
    if (sel[2]) s = s + h2;
    return s;
  endfunction
endpackage

// File: rtl/da_serial_preadd.sv
module da_serial_preadd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic carry_o
);
  logic cy_q;

  assign sum_o   = a_i ^ b_i ^ cy_q;
  assign carry_o = cy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cy_q <= 1'b0;
    else if (clr_i) cy_q <= 1'b0;
    else if (en_i)  cy_q <= (a_i & b_i) | (a_i & cy_q) | (b_i & cy_q);
  end
endmodule

// File: rtl/da_coef_rom.sv
module da_coef_rom
  import da_sym_pkg::*;
#(
  parameter int          H0    = 16,
  parameter int          H1    = -32,
  parameter int          H2    = 96,
  parameter int unsigned TAB_W = 10
) (
  input  logic [TAB_ADDR_W-1:0]    addr_i,
  output logic signed [TAB_W-1:0]  data_o
);
  localparam int unsigned DEPTH = 1 << TAB_ADDR_W;

  logic signed [TAB_W-1:0] tab [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign tab[e] = TAB_W'(da_entry(H0, H1, H2, TAB_ADDR_W'(e)));
  end

  assign data_o = tab[addr_i];
endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAB_W = 10,
  parameter int unsigned ACC_W = 19,
  parameter int unsigned FRAC  = 7,
  parameter int unsigned IDX_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    v_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic signed [TAB_W-1:0] term_i,
  output logic                    valid_o,
  output logic [N-1:0]            y_o
);
  localparam int unsigned RW = ACC_W + 1;
  localparam logic signed [RW-1:0] MAXV = RW'((2 ** (N - 1)) - 1);
  localparam logic signed [RW-1:0] MINV = -MAXV - RW'(1);
  localparam logic signed [RW-1:0] HALF = RW'(2 ** (FRAC - 1));

  logic signed [ACC_W-1:0] acc_q, term_x, term_sh, acc_nx;
  logic signed [RW-1:0]    rnd, quo;
  logic                    first_bit, sign_bit;
  logic [N-1:0]            y_q, y_nx;
  logic                    valid_q;

  assign term_x    = {{(ACC_W - TAB_W){term_i[TAB_W-1]}}, term_i};
  assign term_sh   = term_x <<< idx_i;
  assign first_bit = (idx_i == '0);
  assign sign_bit  = (idx_i == IDX_W'(N));
  assign acc_nx    = (first_bit ? '0 : acc_q) + (sign_bit ? -term_sh : term_sh);

  always_comb begin
    rnd = {acc_nx[ACC_W-1], acc_nx} + HALF;
    quo = rnd >>> FRAC;
    if (quo > MAXV)      y_nx = MAXV[N-1:0];
    else if (quo < MINV) y_nx = MINV[N-1:0];
    else                 y_nx = quo[N-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      y_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= v_i && sign_bit;
      if (v_i) acc_q <= acc_nx;
      if (v_i && sign_bit) y_q <= y_nx;
    end
  end

  assign valid_o = valid_q;
  assign y_o     = y_q;
endmodule

// File: rtl/da_sym_section.sv
module da_sym_section
  import da_sym_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned CW   = 8,
  parameter int unsigned FRAC = 7,
  parameter int          H0   = 16,
  parameter int          H1   = -32,
  parameter int          H2   = 96
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [N-1:0] in_sample_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [N-1:0] out_sample_o
);
  localparam int unsigned NB    = N + 1;
  localparam int unsigned FRAME = NB + PIPE_LAT;
  localparam int unsigned CNT_W = $clog2(FRAME);
  localparam int unsigned IDX_W = $clog2(NB);
  localparam int unsigned TAB_W = CW + 2;
  localparam int unsigned ACC_W = CW + N + 3;

  logic                      busy_q, last_cyc, accept, pre_en;
  logic [CNT_W-1:0]          cnt_q;
  logic [IDX_W-1:0]          bit_idx;
  logic [TAPS-1:0][N-1:0]    hist_q;
  logic [TAPS-1:0][NB-1:0]   sext_w;
  logic [TAPS-1:0]           tap_bit;
  logic                      sum_a, sum_b, carry_a, carry_b;
  logic [TAB_ADDR_W-1:0]     addr1_q;
  logic                      v1_q, v2_q;
  logic [IDX_W-1:0]          idx1_q, idx2_q;
  logic signed [TAB_W-1:0]   rom_data, tab_q;

  // frame control: last cycle of a frame may already take the next sample
  assign last_cyc   = busy_q && (cnt_q == CNT_W'(FRAME - 1));
  assign in_ready_o = !busy_q || last_cyc;
  assign accept     = in_valid_i && in_ready_o;
  assign pre_en     = busy_q && (cnt_q < CNT_W'(NB));
  assign bit_idx    = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_cyc) busy_q <= 1'b0;
      else          cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (accept) begin
      hist_q[0] <= in_sample_i;
      for (int t = 1; t < TAPS; t++) hist_q[t] <= hist_q[t-1];
    end
  end

  // one guard bit per tap keeps the pair sum in range
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign sext_w[g]  = {hist_q[g][N-1], hist_q[g]};
    assign tap_bit[g] = sext_w[g][bit_idx];
  end

  da_serial_preadd u_pre_outer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (pre_en),
    .a_i    (tap_bit[0]),
    .b_i    (tap_bit[4]),
    .sum_o  (sum_a),
    .carry_o(carry_a)
  );

  da_serial_preadd u_pre_inner (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (pre_en),
    .a_i    (tap_bit[1]),
    .b_i    (tap_bit[3]),
    .sum_o  (sum_b),
    .carry_o(carry_b)
  );

  // stage 1: pre-add bits; stage 2: table word; bit index travels alongside
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr1_q <= '0;
      v1_q    <= 1'b0;
      idx1_q  <= '0;
      tab_q   <= '0;
      v2_q    <= 1'b0;
      idx2_q  <= '0;
    end else begin
      addr1_q <= {tap_bit[2], sum_b, sum_a};
      v1_q    <= pre_en;
      idx1_q  <= bit_idx;
      tab_q   <= rom_data;
      v2_q    <= v1_q;
      idx2_q  <= idx1_q;
    end
  end

  da_coef_rom #(
    .H0   (H0),
    .H1   (H1),
    .H2   (H2),
    .TAB_W(TAB_W)
  ) u_rom (
    .addr_i(addr1_q),
    .data_o(rom_data)
  );

  da_scale_acc #(
    .N    (N),
    .TAB_W(TAB_W),
    .ACC_W(ACC_W),
    .FRAC (FRAC),
    .IDX_W(IDX_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (v2_q),
    .idx_i  (idx2_q),
    .term_i (tab_q),
    .valid_o(out_valid_o),
    .y_o    (out_sample_o)
  );
endmodule

// File: rtl/da_sym_section_chk.sv
module da_sym_section_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic [N-1:0] out_sample_o,
  input logic         carry_a,
  input logic         carry_b
);
  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_busy_after_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  assert_hold_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_sample_o));

  // exact pair sums need a clean carry at each frame start
  assert_carry_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (!carry_a && !carry_b));
endmodule

bind da_sym_section da_sym_section_chk #(.N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_sample_o(out_sample_o),
  .carry_a     (carry_a),
  .carry_b     (carry_b)
);

// File: tb/da_sym_section_tb_top.sv
module da_sym_section_tb_top;
  localparam int N     = 8;
  localparam int CW    = 8;
  localparam int FRAC  = 7;
  localparam int H0    = 16;
  localparam int H1    = -32;
  localparam int H2    = 96;
  localparam int FRAME = N + 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [N-1:0] in_sample_i = '0;
  logic         in_ready_o, out_valid_o;
  logic [N-1:0] out_sample_o;

  int total = 0;
  int bad = 0;
  string cur_req = "R2";
  bit run_chk = 1'b0;

  // reference model state
  int hq[$];
  bit m_busy, m_ready, exp_valid;
  int m_cnt, pend, pend_val, exp_out;

  always #4 clk_i = ~clk_i;

  da_sym_section #(
    .N(N), .CW(CW), .FRAC(FRAC), .H0(H0), .H1(H1), .H2(H2)
  ) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_sample_i (in_sample_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_sample_o(out_sample_o)
  );

  function automatic int ref_y(int a0, int a1, int a2, int a3, int a4);
    int s, r;
    s = H0 * (a0 + a4) + H1 * (a1 + a3) + H2 * a2;
    r = (s + (1 << (FRAC - 1))) >>> FRAC;
    if (r > (2 ** (N - 1)) - 1) r = (2 ** (N - 1)) - 1;
    if (r < -(2 ** (N - 1)))    r = -(2 ** (N - 1));
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hq = {0, 0, 0, 0, 0};
      m_busy = 0; m_cnt = 0; m_ready = 1;
      pend = 0; pend_val = 0; exp_valid = 0; exp_out = 0;
    end else begin
      bit take;
      take = in_valid_i && m_ready;
      exp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin exp_valid = 1; exp_out = pend_val; end
      end
      if (take) begin
        m_busy = 1; m_cnt = 0;
        hq.push_front(int'($signed(in_sample_i)));
        void'(hq.pop_back());
        pend = FRAME;
        pend_val = ref_y(hq[0], hq[1], hq[2], hq[3], hq[4]);
      end else if (m_busy) begin
        if (m_cnt == FRAME - 1) m_busy = 0;
        else m_cnt++;
      end
      m_ready = !m_busy || (m_cnt == FRAME - 1);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (run_chk) begin
      int act;
      act = int'($signed(out_sample_o));
      total++;
      if (in_ready_o !== m_ready) begin
        bad++;
        $display("FAIL R4 in_ready_o act=%0b exp=%0b", in_ready_o, m_ready);
      end
      total++;
      if (out_valid_o !== exp_valid) begin
        bad++;
        $display("FAIL R3 out_valid_o act=%0b exp=%0b", out_valid_o, exp_valid);
      end
      total++;
      if (act != exp_out) begin
        bad++;
        $display("FAIL %s out_sample_o act=%0d exp=%0d", exp_valid ? cur_req : "R10", act, exp_out);
      end
    end
  end

  task automatic push(input int x);
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1;
    in_sample_i = N'(x);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // junk offered while busy must be ignored
  task automatic push_with_junk(input int x, input int junk);
    push(x);
    in_valid_i = 1'b1;
    in_sample_i = N'(junk);
    repeat (FRAME - 3) @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic stream(input int cnt);
    int sent;
    sent = 0;
    in_valid_i = 1'b1;
    while (sent < cnt) begin
      @(negedge clk_i);
      if (in_ready_o) begin
        in_sample_i = N'($urandom());
        sent++;
      end
    end
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) push(0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    total++;
    if (in_ready_o !== 1'b1 || out_valid_o !== 1'b0 || out_sample_o !== '0) begin
      bad++;
      $display("FAIL R1 reset act=%0b/%0b/%0d exp=1/0/0", in_ready_o, out_valid_o, out_sample_o);
    end
    rst_ni = 1'b1;
    run_chk = 1'b1;
    @(negedge clk_i);
    total++;
    if (in_ready_o !== 1'b1 || out_valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 after release act=%0b/%0b exp=1/0", in_ready_o, out_valid_o);
    end

    cur_req = "R2";
    for (int i = 0; i < 30; i++) push(int'($urandom_range(255)));
    push(64); push(0); push(0); push(0); push(0);

    cur_req = "R5";
    for (int i = 0; i < 8; i++) push_with_junk(int'($urandom_range(255)), 127);

    cur_req = "R6";
    for (int i = 0; i < 5; i++) push(-128);
    for (int i = 0; i < 5; i++) push(127);
    push(-128); push(0); push(0); push(0); push(-128);

    cur_req = "R7";
    flush(); push(4);
    flush(); push(-4);
    flush(); push(12);

    cur_req = "R8";
    flush();
    push(127); push(-128); push(127); push(-128); push(127);
    push(-128); push(127); push(-128); push(127); push(-128);

    cur_req = "R9";
    stream(40);

    repeat (FRAME + 4) @(negedge clk_i);
    run_chk = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule